// File: doc/BRIEF.md
# Four-Channel Counter/Timer with Ring Cascade

This block provides four independent 8-bit down-counting channels that share one fixed system clock, which does not change with processor speed. Software programs each channel through its own byte-wide I/O port. A byte with bit 0 set is a control byte. If that byte asks for it, the next byte is a time constant. Reading the port returns the live count. A running channel works in one of two ways. As a timer, it counts pulses from a shared free-running prescaler that divides the clock by 16 or by 256. As a counter, it counts edges of the previous channel's zero-count pulse. The channels form a ring, with 3 feeding 0, 0 feeding 1, 1 feeding 2 and 2 feeding 3.

Each channel drives a one-cycle zero-count pulse. Interrupt and DMA logic elsewhere can pick it up, together with the channel's interrupt-enable flag. The port slots for channels four to seven are reserved. A stale control sequence can always be cleared by writing the same soft-reset byte twice.

Top module: `ctc_quad`

## Requirements
- R1: A port access selects channel n when io_addr[15:11] = 5'b00011, io_addr[10:8] = n and io_addr[7:0] = 8'h3B. For n = 4 to 7, or for any other address, reads return 0 and writes change nothing.
- R2: When no time constant is pending, a written byte with bit 0 = 1 is a control byte. Its fields are: bit 7 interrupt enable (shown on irq_enable[n]), bit 6 counter mode, bit 5 divide-by-256 prescale (otherwise divide-by-16), bit 4 rising trigger edge (otherwise falling), bit 3 wait for trigger, bit 2 time constant follows, and bit 1 soft reset. irq_enable changes only in the cycle after a write.
- R3: After the chip reset, a channel stays halted with count 0 and produces no zero-count pulse. It starts only after a control byte with bit 2 = 1 followed by a time-constant byte.
- R4: While a time constant is pending, the next byte written is taken as the constant whatever its bit 0. Two writes of 8'h03 therefore always leave the channel halted and waiting for a control byte.
- R5: In timer mode, the count decrements once per prescaler pulse. The prescaler is free running and no channel write restarts it. The zero-count period is constant × 16 clocks, or constant × 256 clocks with bit 5 set.
- R6: When a decrement takes the count to zero, the channel emits a zero-count pulse exactly one cycle wide, reloads the time constant and keeps counting. A constant of 0 gives a period of 256 decrements.
- R7: In counter mode, the prescaler is bypassed. The count decrements on the selected edge of the previous channel's zero-count pulse, with the ring ordered 3→0, 0→1, 1→2, 2→3.
- R8: A control byte that moves the trigger edge from rising to falling while the trigger is low acts as one trigger edge, so a running counter-mode channel decrements once. Moving it back from falling to rising does not decrement.
- R9: In timer mode with bit 3 set, the channel holds its constant after loading until a trigger edge arrives, then counts. With bit 3 clear, it counts from the clock after the load.
- R10: A read returns the channel's current count. A halted channel returns its last loaded constant (0 if none). io_rdata is 0 when io_rd is low.
- R11: A byte with bit 0 = 0 written while no constant is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed system clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data, live count of the addressed channel |
| zc_pulse | output | 4 | One-cycle zero-count/timeout pulse per channel |
| irq_enable | output | 4 | Interrupt-enable bit of each channel's control byte |

## Verification
The assertions assume that io_wr and io_rd are single-cycle strobes that never occur together, and that io_addr and io_wdata are stable around the clock edge where a strobe is high. They also assume the chip reset leaves io_wr low. The bench drives every access from a task on the falling clock edge and issues at most one access per cycle. It releases io_wr in the next cycle and holds the strobes low during reset, so the stimulus never leaves these bounds.

// File: rtl/ctc_pkg.sv
// Shared definitions for the four-channel counter/timer.
// Assumes a byte-wide bus; control bit positions are fixed by software.
package ctc_pkg;

    localparam int CW_IE   = 7;
    localparam int CW_CNT  = 6;
    localparam int CW_P256 = 5;
    localparam int CW_RISE = 4;
    localparam int CW_WAIT = 3;
    localparam int CW_TCF  = 2;
    localparam int CW_SRST = 1;
    localparam int CW_CTL  = 0;

    typedef enum logic [1:0] {
        CH_HALT  = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_t;

    typedef struct packed {
        logic ie;
        logic cnt_mode;
        logic div_hi;
        logic rise;
        logic wait_trg;
    } ch_cfg_t;

endpackage

// File: rtl/ctc_prescaler.sv
// Free-running prescaler shared by all channels.
// Emits a one-cycle pulse every 2**LO_BITS clocks and every 2**W clocks.
// Assumes only the chip reset clears it; channel programming never does.
module ctc_prescaler #(
    parameter int W       = 8,
    parameter int LO_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_lo,
    output logic tick_hi
);

    logic [W-1:0] pre_q;

    // Advance the prescaler on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Pulse at the last state of each division window.
    always_comb begin
        tick_lo = &pre_q[LO_BITS-1:0];
        tick_hi = &pre_q;
    end

endmodule

// File: rtl/ctc_decode.sv
// Port decoder: full match on the fixed address bits, with a slot field
// choosing the channel. Slots at or above NCH select nothing.
module ctc_decode #(
    parameter int          NCH       = 4,
    parameter int          SLOT_BITS = 3,
    parameter int          SLOT_LSB  = 8,
    parameter logic [15:0] BASE      = 16'h183B
) (
    input  logic [15:0]    addr,
    output logic [NCH-1:0] sel
);

    localparam logic [15:0] SLOT_MASK = 16'(((1 << SLOT_BITS) - 1) << SLOT_LSB);
    localparam logic [15:0] FIX_MASK  = ~SLOT_MASK;

    logic                 fixed_ok;
    logic [SLOT_BITS-1:0] slot;

    // Compare the fixed bits and extract the slot number.
    always_comb begin
        fixed_ok = (addr & FIX_MASK) == (BASE & FIX_MASK);
        slot     = addr[SLOT_LSB +: SLOT_BITS];
    end

    // One select line per implemented channel.
    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign sel[i] = fixed_ok && (slot == SLOT_BITS'(i));
    end

endmodule

// File: rtl/ctc_channel.sv
// One counter/timer channel: control/time-constant write sequencing,
// trigger edge detection and the down-counter with reload.
// Assumes wr_en is a single-cycle strobe and trig is a registered pulse.
module ctc_channel
    import ctc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wdata,
    input  logic          pre_lo,
    input  logic          pre_hi,
    input  logic          trig,
    output logic [CW-1:0] count_o,
    output logic          zc_o,
    output logic          ie_o
);

    ch_state_t     st_q;
    ch_cfg_t       cfg_q;
    logic          tc_pend_q;
    logic [CW-1:0] tc_q;
    logic [CW-1:0] cnt_q;
    logic          zc_q;
    logic          pol_q;

    logic pol;
    logic trg_edge;
    logic tick;
    logic is_tc;
    logic is_cw;

    // Trigger polarity, edge detection and the decrement source.
    always_comb begin
        pol      = cfg_q.rise ? trig : ~trig;
        trg_edge = pol & ~pol_q;
        tick     = cfg_q.cnt_mode ? trg_edge : (cfg_q.div_hi ? pre_hi : pre_lo);
        is_tc    = wr_en & tc_pend_q;
        is_cw    = wr_en & ~tc_pend_q & wdata[CW_CTL];
    end

    // Sequencing of writes, counting and the zero-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= CH_HALT;
            cfg_q     <= '0;
            tc_pend_q <= 1'b0;
            tc_q      <= '0;
            cnt_q     <= '0;
            zc_q      <= 1'b0;
            pol_q     <= 1'b1;
        end else begin
            pol_q <= pol;
            zc_q  <= 1'b0;
            unique case (st_q)
                CH_ARMED: if (trg_edge) st_q <= CH_RUN;
                CH_RUN: begin
                    if (tick) begin
                        if (cnt_q == CW'(1)) begin
                            cnt_q <= tc_q;
                            zc_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
            if (is_tc) begin
                tc_q      <= wdata;
                tc_pend_q <= 1'b0;
                if (st_q == CH_HALT) begin
                    cnt_q <= wdata;
                    st_q  <= (!cfg_q.cnt_mode && cfg_q.wait_trg) ? CH_ARMED : CH_RUN;
                end
            end else if (is_cw) begin
                cfg_q.ie       <= wdata[CW_IE];
                cfg_q.cnt_mode <= wdata[CW_CNT];
                cfg_q.div_hi   <= wdata[CW_P256];
                cfg_q.rise     <= wdata[CW_RISE];
                cfg_q.wait_trg <= wdata[CW_WAIT];
                tc_pend_q      <= wdata[CW_TCF];
                if (wdata[CW_SRST]) begin
                    st_q  <= CH_HALT;
                    cnt_q <= tc_q;
                    zc_q  <= 1'b0;
                end
            end
        end
    end

    assign count_o = cnt_q;
    assign zc_o    = zc_q;
    assign ie_o    = cfg_q.ie;

endmodule

// File: rtl/ctc_quad.sv
// Four-channel counter/timer. Channels share one prescaler and are
// chained in a ring through their registered zero-count pulses.
// Assumes single-cycle io_wr strobes and stable address/data around them.
module ctc_quad #(
    parameter int          NCH       = 4,
    parameter int          CW        = 8,
    parameter int          PRE_W     = 8,
    parameter int          PRE_LO    = 4,
    parameter int          SLOT_BITS = 3,
    parameter logic [15:0] BASE      = 16'h183B
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [15:0]    io_addr,
    input  logic           io_wr,
    input  logic           io_rd,
    input  logic [7:0]     io_wdata,
    output logic [CW-1:0]  io_rdata,
    output logic [NCH-1:0] zc_pulse,
    output logic [NCH-1:0] irq_enable
);

    logic          pre_lo;
    logic          pre_hi;
    logic [NCH-1:0] sel;
    logic [CW-1:0] cnt [NCH];

    ctc_prescaler #(.W(PRE_W), .LO_BITS(PRE_LO)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_lo(pre_lo),
        .tick_hi(pre_hi)
    );

    ctc_decode #(.NCH(NCH), .SLOT_BITS(SLOT_BITS), .SLOT_LSB(8), .BASE(BASE)) u_dec (
        .addr(io_addr),
        .sel (sel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int PREV = (i + NCH - 1) % NCH;
        ctc_channel #(.CW(CW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (io_wr & sel[i]),
            .wdata  (io_wdata),
            .pre_lo (pre_lo),
            .pre_hi (pre_hi),
            .trig   (zc_pulse[PREV]),
            .count_o(cnt[i]),
            .zc_o   (zc_pulse[i]),
            .ie_o   (irq_enable[i])
        );
    end

    // Read-back multiplexer; unselected or reserved slots read zero.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            for (int i = 0; i < NCH; i++) begin
                if (sel[i]) io_rdata = cnt[i];
            end
        end
    end

endmodule

// File: rtl/ctc_quad_chk.sv
// Assertion checker for ctc_quad, attached with bind.
module ctc_quad_chk #(
    parameter int NCH = 4,
    parameter int CW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [15:0]    io_addr,
    input logic           io_wr,
    input logic           io_rd,
    input logic [CW-1:0]  io_rdata,
    input logic [NCH-1:0] zc_pulse,
    input logic [NCH-1:0] irq_enable
);

    logic seen_wr_q;

    // Remember whether any write has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     seen_wr_q <= 1'b0;
        else if (io_wr) seen_wr_q <= 1'b1;
    end

    // R1: reserved slots 4..7 read zero
    assert_rd_void_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr[15:11] == 5'b00011 && io_addr[10] && io_addr[7:0] == 8'h3B)
        |-> io_rdata == '0);

    // R2: interrupt enables move only after a write
    assert_ie_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(io_wr) |-> $stable(irq_enable));

    // R3: no zero-count pulse before any channel was programmed
    assert_quiet_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_wr_q |-> zc_pulse == '0);

    // R10: bus is quiet without a read strobe
    assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_zc
        // R6: zero-count pulse lasts one cycle
        assert_zc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
            zc_pulse[i] |=> !zc_pulse[i]);
    end

endmodule

bind ctc_quad ctc_quad_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_rdata  (io_rdata),
    .zc_pulse  (zc_pulse),
    .irq_enable(irq_enable)
);

// File: tb/sim_ctc_quad.sv
// Directed bench for ctc_quad: one task per scenario.
module sim_ctc_quad;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  zc_pulse;
    logic [3:0]  irq_enable;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam int WATCHDOG = 150000;

    always #5 clk = ~clk;

    ctc_quad u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .zc_pulse  (zc_pulse),
        .irq_enable(irq_enable)
    );

    function automatic logic [15:0] chp(input int ch);
        return 16'h183B + 16'(ch << 8);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output int v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 v = int'(io_rdata);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic idle_zc(input int n, input int ch, output int cnt);
        cnt = 0;
        repeat (n) begin
            @(negedge clk);
            if (zc_pulse[ch]) cnt++;
        end
    endtask

    task automatic period(input int ch, output int p);
        int n;
        n = 0;
        while (!zc_pulse[ch] && n < 20000) begin @(negedge clk); n++; end
        p = 0;
        do begin @(negedge clk); p++; end while (!zc_pulse[ch] && p < 20000);
    endtask

    task automatic t_reset();
        int v;
        for (int i = 0; i < 4; i++) begin
            rd(chp(i), v);
            chk("R10 reset count", v, 0);
        end
        chk("R3 no pulse at reset", int'(zc_pulse), 0);
    endtask

    task automatic t_power_on();
        int v, z;
        wr(chp(0), 8'h01);            // control, no constant follows
        wr(chp(0), 8'h08);            // vector byte, ignored (R11)
        idle_zc(40, 0, z);
        chk("R3 halted without constant flag", z, 0);
        rd(chp(0), v);
        chk("R11 vector byte ignored", v, 0);
        wr(chp(0), 8'h05);            // constant pending, not yet started
        idle_zc(40, 0, z);
        chk("R3 halted until constant", z, 0);
    endtask

    task automatic t_timer16();
        int v, p;
        wr(chp(0), 8'h04);
        rd(chp(0), v);
        chk("R10 count after load", v, 4);
        period(0, p);
        rd(chp(0), v);
        chk("R6 reload after zero", v, 4);
        period(0, p);
        chk("R5 period div16 tc4", p, 64);
    endtask

    task automatic t_timer256();
        int p;
        wr(chp(1), 8'h27);
        wr(chp(1), 8'h02);
        period(1, p);
        period(1, p);
        chk("R5 period div256 tc2", p, 512);
    endtask

    task automatic t_tc_zero();
        int v, p;
        wr(chp(2), 8'h07);
        wr(chp(2), 8'h00);
        rd(chp(2), v);
        chk("R10 count after zero load", v, 0);
        period(2, p);
        period(2, p);
        chk("R6 constant 0 is 256", p, 4096);
    endtask

    task automatic t_cascade();
        int p;
        wr(chp(0), 8'h07); wr(chp(0), 8'h02);
        wr(chp(1), 8'h57); wr(chp(1), 8'h03);
        period(1, p);
        period(1, p);
        chk("R7 channel 1 fed by channel 0", p, 96);
        wr(chp(3), 8'h07); wr(chp(3), 8'h01);
        wr(chp(0), 8'h57); wr(chp(0), 8'h02);
        period(0, p);
        period(0, p);
        chk("R7 channel 0 fed by channel 3", p, 32);
    endtask

    task automatic t_bad_ports();
        int v, z;
        wr(chp(0), 8'h03); wr(chp(0), 8'h03);
        rd(chp(0), v);
        chk("R10 halted reads constant", v, 2);
        wr(16'h1C3B, 8'h05); wr(16'h1C3B, 8'h07);
        rd(16'h1C3B, v);
        chk("R1 slot 4 reads zero", v, 0);
        rd(16'h1F3B, v);
        chk("R1 slot 7 reads zero", v, 0);
        wr(16'h183C, 8'h05); wr(16'h183C, 8'h09);
        rd(16'h183C, v);
        chk("R1 wrong low byte reads zero", v, 0);
        idle_zc(300, 0, z);
        chk("R1 stray writes do not start channel 0", z, 0);
        rd(chp(0), v);
        chk("R1 channel 0 unchanged", v, 2);
    endtask

    task automatic t_soft_reset();
        int v, z;
        wr(chp(2), 8'h85);
        chk("R2 interrupt enable set", int'(irq_enable[2]), 1);
        wr(chp(2), 8'h03);            // consumed as constant (R4)
        wr(chp(2), 8'h03);            // control byte: soft reset
        chk("R2 interrupt enable cleared", int'(irq_enable[2]), 0);
        rd(chp(2), v);
        chk("R4 first reset byte taken as constant", v, 3);
        idle_zc(300, 2, z);
        chk("R4 halted after two resets", z, 0);
        rd(chp(2), v);
        chk("R4 count frozen", v, 3);
    endtask

    task automatic t_wait_trigger();
        int v, z, p;
        wr(chp(0), 8'h03);
        wr(chp(1), 8'h1F);
        wr(chp(1), 8'h02);
        idle_zc(100, 1, z);
        chk("R9 no pulse before trigger", z, 0);
        rd(chp(1), v);
        chk("R9 count held before trigger", v, 2);
        wr(chp(0), 8'h07); wr(chp(0), 8'h01);
        period(1, p);
        period(1, p);
        chk("R9 runs after trigger", p, 32);
    endtask

    task automatic t_edge_change();
        int v;
        wr(chp(3), 8'h57);
        wr(chp(3), 8'h05);
        rd(chp(3), v);
        chk("R8 loaded", v, 5);
        wr(chp(3), 8'h41);
        rd(chp(3), v);
        chk("R8 rising to falling decrements", v, 4);
        wr(chp(3), 8'h51);
        rd(chp(3), v);
        chk("R8 falling to rising holds", v, 4);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
            summary();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_power_on();
        t_timer16();
        t_timer256();
        t_tc_zero();
        t_cascade();
        t_bad_ports();
        t_soft_reset();
        t_wait_trigger();
        t_edge_change();
        summary();
    end

endmodule